// File: doc/BRIEF.md
# DMA Channel and Bus-Ownership Arbiter

This block chooses which DMA channel the transfer engine should serve next, and it decides each cycle whether the processor or the DMA engine drives the shared system bus. Each channel has a request line, an enable bit and an urgent bit. Channels with the urgent bit set form an upper tier, and every channel in that tier beats every channel outside it. Inside a tier, the lowest channel index wins. Requests from disabled channels are ignored.

The channel choice is stored in a register. It changes only when the engine pulses its arbitration-point strobe. The engine pulses this strobe after a burst of 2^R unit transfers or when a cycle ends. Between strobes the grant holds, even if the requests change. A long transfer therefore yields to a more urgent channel only at its next strobe.

Bus ownership is decided in the same cycle as the bus requests. If only one master requests the bus, that master gets it. If both request, ownership alternates each cycle, so neither master starves.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is held and after it is released, `chan_grant` is all zeros and `chan_grant_valid` is low until the first arbitration strobe.
- R2: A channel whose `chan_enable` bit is 0 is never granted, even when its `chan_req` bit is 1.
- R3: Among eligible channels of the same tier, the one with the lowest index is granted. `chan_grant` is one-hot, with bit i meaning channel i.
- R4: An eligible channel whose `chan_urgent` bit is 1 always wins over any eligible channel whose `chan_urgent` bit is 0. An urgent bit on a channel that is not eligible has no effect.
- R5: `chan_grant` and `chan_grant_valid` are loaded on the rising edge where `arb_point` is 1, and they are visible from that edge on. On every other edge they keep their value. A more urgent request that arrives mid-transfer therefore takes over only at the next strobe.
- R6: If no channel is both requesting and enabled at a strobe, `chan_grant_valid` becomes 0 and `chan_grant` becomes all zeros.
- R7: When exactly one of `cpu_bus_req` and `dma_bus_req` is 1, that master's grant output is 1 in that same cycle, on every cycle.
- R8: When both masters request, the grant goes to the master that was not granted most recently. The first contested cycle after reset goes to the DMA. Back-to-back contested cycles alternate owners.
- R9: When neither master requests, both bus grants are 0, and the record of the most recently granted master is kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_req | input | NUM_CH | Request bit per channel |
| chan_enable | input | NUM_CH | Enable bit per channel |
| chan_urgent | input | NUM_CH | Upper-tier priority bit per channel |
| arb_point | input | 1 | Strobe from the engine: re-arbitrate on this edge |
| cpu_bus_req | input | 1 | Processor requests the bus |
| dma_bus_req | input | 1 | DMA engine requests the bus |
| chan_grant | output | NUM_CH | Registered one-hot channel grant |
| chan_grant_valid | output | 1 | Registered: a channel is granted |
| bus_gnt_cpu | output | 1 | Processor owns the bus this cycle |
| bus_gnt_dma | output | 1 | DMA owns the bus this cycle |

## Verification
The hardest case to reach is pre-emption. A lower channel must already hold the grant while an urgent request rises, and that request must be seen to have no effect until the strobe. The stimulus first grants a low-urgency channel with one strobe. It then raises an urgent request on another channel and runs several edges with the strobe low, checking that the old grant stays. Only then does it pulse the strobe and check the change. The bus-alternation memory is reached in a similar way: a cycle with one requester and an idle stretch come before a contested cycle, so the bench can show that the owner chosen under contention depends on history that idle cycles do not erase.

// File: rtl/dma_arb_pkg.sv
// Package: shared types for the DMA request arbiter.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package dma_arb_pkg;

    // Identifies which master holds (or last held) the system bus.
    typedef enum logic {
        OWNER_CPU = 1'b0,
        OWNER_DMA = 1'b1
    } bus_owner_e;

endpackage

// File: rtl/dma_arb_lowest_pick.sv
// Module: dma_arb_lowest_pick
// Returns a one-hot vector marking the lowest-index set bit of the input,
// plus a flag telling whether any bit was set. Purely combinational.
// Assumes WIDTH >= 1.
module dma_arb_lowest_pick #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cand,
    output logic [WIDTH-1:0] pick,
    output logic             any_set
);

    // seen[i] is 1 when some bit below index i is set.
    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;

    // Prefix chain: each bit wins only if no lower bit already won.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chain
            assign pick[i]     = cand[i] & ~seen[i];
            assign seen[i+1]   = seen[i] | cand[i];
        end
    endgenerate

    assign any_set = seen[WIDTH];

    // Immediate check that the chain never marks two winners (R3).
    always_comb begin
        assert_pick_onehot_R3: assert ($onehot0(pick));
    end

endmodule

// File: rtl/dma_arb_chan_sel.sv
// Module: dma_arb_chan_sel
// Two-tier channel selection. Eligible = request & enable. The urgent tier
// is searched first, then the normal tier, each lowest index first.
// The result is registered and only reloaded on an arbitration strobe.
// Assumes synchronous active-low reset and single-cycle strobes.
module dma_arb_chan_sel #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] enable,
    input  logic [NUM_CH-1:0] urgent,
    input  logic              arb_point,
    output logic [NUM_CH-1:0] grant,
    output logic              grant_valid
);

    logic [NUM_CH-1:0] eligible;
    logic [NUM_CH-1:0] tier_hi;
    logic [NUM_CH-1:0] tier_lo;
    logic [NUM_CH-1:0] pick_hi;
    logic [NUM_CH-1:0] pick_lo;
    logic              any_hi;
    logic              any_lo;
    logic [NUM_CH-1:0] next_grant;

    // Mask disabled channels, then split eligible set by tier.
    always_comb begin
        eligible = req & enable;
        tier_hi  = eligible & urgent;
        tier_lo  = eligible & ~urgent;
    end

    dma_arb_lowest_pick #(.WIDTH(NUM_CH)) i_pick_hi (
        .cand    (tier_hi),
        .pick    (pick_hi),
        .any_set (any_hi)
    );

    dma_arb_lowest_pick #(.WIDTH(NUM_CH)) i_pick_lo (
        .cand    (tier_lo),
        .pick    (pick_lo),
        .any_set (any_lo)
    );

    // Upper tier wins whenever it has any candidate.
    always_comb begin
        next_grant = any_hi ? pick_hi : pick_lo;
    end

    // Grant register: reload only at an arbitration point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant       <= '0;
            grant_valid <= 1'b0;
        end else if (arb_point) begin
            grant       <= next_grant;
            grant_valid <= any_hi | any_lo;
        end
    end

    // Grant never changes between strobes.
    assert_grant_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_point |=> $stable(grant) && $stable(grant_valid));

    // Granted channel was requesting and enabled at the strobe.
    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arb_point |=> ((grant & ~$past(req & enable)) == '0));

    // Nothing eligible at strobe gives an empty, invalid grant.
    assert_empty_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_point && ((req & enable) == '0)) |=> (!grant_valid && grant == '0));

    // Any eligible urgent channel forces an urgent winner.
    assert_urgent_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_point && ((req & enable & urgent) != '0)) |=> ((grant & $past(urgent)) != '0));

    // Valid flag agrees with a single set grant bit.
    assert_grant_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == ($countones(grant) == 1) && $onehot0(grant));

endmodule

// File: rtl/dma_arb_bus_alt.sv
// Module: dma_arb_bus_alt
// Per-cycle bus owner between the processor and the DMA engine.
// A sole requester is granted at once; under contention the master not
// granted most recently wins. Idle cycles leave the history untouched.
// Grants are combinational from the requests and one history flop.
module dma_arb_bus_alt
    import dma_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic dma_req,
    output logic gnt_cpu,
    output logic gnt_dma
);

    bus_owner_e last_owner;

    // Decide owner for this cycle from requests and history.
    always_comb begin
        gnt_cpu = 1'b0;
        gnt_dma = 1'b0;
        if (cpu_req && dma_req) begin
            if (last_owner == OWNER_CPU) gnt_dma = 1'b1;
            else                         gnt_cpu = 1'b1;
        end else if (cpu_req) begin
            gnt_cpu = 1'b1;
        end else if (dma_req) begin
            gnt_dma = 1'b1;
        end
    end

    // History: remember the most recent granted master.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_owner <= OWNER_CPU;
        else if (gnt_dma) last_owner <= OWNER_DMA;
        else if (gnt_cpu) last_owner <= OWNER_CPU;
    end

    // Never two owners at once.
    assert_bus_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_cpu && gnt_dma));

    // Sole requester always receives the bus.
    assert_sole_cpu_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !dma_req) |-> gnt_cpu);
    assert_sole_dma_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !cpu_req) |-> gnt_dma);

    // Consecutive contested cycles swap owner.
    assert_alternate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req) ##1 (cpu_req && dma_req) |-> (gnt_dma != $past(gnt_dma)));

    // Idle bus grants nobody.
    assert_idle_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req && !dma_req) |-> (!gnt_cpu && !gnt_dma));

endmodule

// File: rtl/dma_req_arbiter.sv
// Module: dma_req_arbiter (top)
// Chooses the next DMA channel at engine arbitration points and decides
// per-cycle bus ownership between processor and DMA engine.
// Assumes all inputs synchronous to clk; synchronous active-low reset.
module dma_req_arbiter #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic [NUM_CH-1:0] chan_enable,
    input  logic [NUM_CH-1:0] chan_urgent,
    input  logic              arb_point,
    input  logic              cpu_bus_req,
    input  logic              dma_bus_req,
    output logic [NUM_CH-1:0] chan_grant,
    output logic              chan_grant_valid,
    output logic              bus_gnt_cpu,
    output logic              bus_gnt_dma
);

    dma_arb_chan_sel #(.NUM_CH(NUM_CH)) i_chan_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (chan_req),
        .enable      (chan_enable),
        .urgent      (chan_urgent),
        .arb_point   (arb_point),
        .grant       (chan_grant),
        .grant_valid (chan_grant_valid)
    );

    dma_arb_bus_alt i_bus_alt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_req (cpu_bus_req),
        .dma_req (dma_bus_req),
        .gnt_cpu (bus_gnt_cpu),
        .gnt_dma (bus_gnt_dma)
    );

    // Reset leaves the grant empty until a strobe arrives.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (chan_grant == '0 && !chan_grant_valid));

endmodule

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;

    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] chan_req;
    logic [NCH-1:0] chan_enable;
    logic [NCH-1:0] chan_urgent;
    logic           arb_point;
    logic           cpu_bus_req;
    logic           dma_bus_req;
    logic [NCH-1:0] chan_grant;
    logic           chan_grant_valid;
    logic           bus_gnt_cpu;
    logic           bus_gnt_dma;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dma_req_arbiter #(.NUM_CH(NCH)) i_dma_req_arbiter (
        .clk              (clk),
        .rst_n            (rst_n),
        .chan_req         (chan_req),
        .chan_enable      (chan_enable),
        .chan_urgent      (chan_urgent),
        .arb_point        (arb_point),
        .cpu_bus_req      (cpu_bus_req),
        .dma_bus_req      (dma_bus_req),
        .chan_grant       (chan_grant),
        .chan_grant_valid (chan_grant_valid),
        .bus_gnt_cpu      (bus_gnt_cpu),
        .bus_gnt_dma      (bus_gnt_dma)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive channel inputs, pulse the strobe for one edge, sample after it.
    task automatic strobe(input logic [NCH-1:0] r, input logic [NCH-1:0] e, input logic [NCH-1:0] u);
        @(negedge clk);
        chan_req = r; chan_enable = e; chan_urgent = u; arb_point = 1'b1;
        @(negedge clk);
        arb_point = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; chan_req = '1; chan_enable = '1; chan_urgent = '0;
        arb_point = 1'b1; cpu_bus_req = 1'b0; dma_bus_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 grant in reset", 32'(chan_grant), 32'h0);
        arb_point = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grant after reset", 32'(chan_grant), 32'h0);
        chk("R1 valid after reset", 32'(chan_grant_valid), 32'h0);
    endtask

    // Drive bus requests for one cycle and check grants mid-cycle.
    task automatic bus_cycle(input string req, input logic c, input logic d,
                             input logic exp_c, input logic exp_d);
        @(negedge clk);
        cpu_bus_req = c; dma_bus_req = d;
        #2;
        chk({req, " cpu grant"}, 32'(bus_gnt_cpu), 32'(exp_c));
        chk({req, " dma grant"}, 32'(bus_gnt_dma), 32'(exp_d));
    endtask

    task automatic t_bus();
        bus_cycle("R8 first contest", 1, 1, 0, 1);
        bus_cycle("R8 second contest", 1, 1, 1, 0);
        bus_cycle("R8 third contest", 1, 1, 0, 1);
        bus_cycle("R7 cpu alone", 1, 0, 1, 0);
        bus_cycle("R7 cpu alone again", 1, 0, 1, 0);
        bus_cycle("R9 idle", 0, 0, 0, 0);
        bus_cycle("R9 idle again", 0, 0, 0, 0);
        bus_cycle("R9 history kept contest", 1, 1, 0, 1);
        bus_cycle("R7 dma alone", 0, 1, 0, 1);
        bus_cycle("R8 contest after dma", 1, 1, 1, 0);
        bus_cycle("R9 idle end", 0, 0, 0, 0);
    endtask

    task automatic t_lowest();
        strobe(8'b0010_1100, 8'hFF, 8'h00);
        chk("R3 lowest of 2,3,5", 32'(chan_grant), 32'h04);
        chk("R3 valid", 32'(chan_grant_valid), 32'h1);
        strobe(8'b1000_0000, 8'hFF, 8'h00);
        chk("R3 single top channel", 32'(chan_grant), 32'h80);
    endtask

    task automatic t_mask();
        strobe(8'b0010_1100, 8'b1111_0011, 8'h00);
        chk("R2 disabled 2,3 skipped", 32'(chan_grant), 32'h20);
        strobe(8'b0000_0001, 8'b1111_1110, 8'h00);
        chk("R2 only disabled requester", 32'(chan_grant), 32'h00);
        chk("R2 valid low", 32'(chan_grant_valid), 32'h0);
    endtask

    task automatic t_urgent();
        strobe(8'b1001_0001, 8'hFF, 8'b1000_0000);
        chk("R4 urgent 7 over 0,4", 32'(chan_grant), 32'h80);
        strobe(8'b1000_0001, 8'hFF, 8'b0000_0010);
        chk("R4 urgent bit on idle channel", 32'(chan_grant), 32'h01);
        strobe(8'b1000_0001, 8'h7F, 8'b1000_0000);
        chk("R4 urgent but disabled", 32'(chan_grant), 32'h01);
        strobe(8'b0110_0000, 8'hFF, 8'b0110_0000);
        chk("R4 lowest inside urgent tier", 32'(chan_grant), 32'h20);
    endtask

    task automatic t_preempt();
        strobe(8'b0100_0000, 8'hFF, 8'h00);
        chk("R5 initial grant ch6", 32'(chan_grant), 32'h40);
        chan_req = 8'b1100_0001; chan_urgent = 8'b1000_0000;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 held without strobe", 32'(chan_grant), 32'h40);
        end
        chan_req = 8'h00;
        @(negedge clk);
        chk("R5 held with no requests", 32'(chan_grant_valid), 32'h1);
        strobe(8'b1100_0001, 8'hFF, 8'b1000_0000);
        chk("R5 pre-empted at strobe", 32'(chan_grant), 32'h80);
    endtask

    task automatic t_none();
        strobe(8'h00, 8'hFF, 8'hFF);
        chk("R6 grant empty", 32'(chan_grant), 32'h00);
        chk("R6 valid low", 32'(chan_grant_valid), 32'h0);
        @(negedge clk);
        chk("R6 stays empty", 32'(chan_grant), 32'h00);
    endtask

    initial begin
        rst_n = 1'b0; chan_req = '0; chan_enable = '0; chan_urgent = '0;
        arb_point = 1'b0; cpu_bus_req = 1'b0; dma_bus_req = 1'b0;
        do_reset();
        t_bus();
        t_lowest();
        t_mask();
        t_urgent();
        t_preempt();
        t_none();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule